// File: doc/BRIEF.md
# Flash Command Register Controller

This block lets software drive a flash bus one command at a time through a small bank of 32-bit registers on an APB port. Software loads a 22-bit flash address and a 32-bit data word, then writes a command code into the control register. The block presents the command on a valid/ready request channel. Once the far side takes it, the block waits for a single-cycle response that either completes normally or reports an error. Read commands that complete normally return their data into the data register.

Every step of a command raises a status bit in an eight-bit interrupt bank. The bank has write-one-to-set and write-one-to-clear views for the enables and for the status, a masked view, and one interrupt line. The four upper status bits are set by event inputs from neighbouring logic. Software cannot reprogram the command, address or data registers while a command is outstanding or while any of its result bits is still set. Such a write is dropped and flagged instead, so each result has to be serviced before the next command can be loaded.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset every register reads zero, `irq` is low, and `cmd_valid` and `cmd_abort` are low.
- R2: An APB write with any `pstrb` bit low changes no register and starts nothing.
- R3: Writing ones to 0x000 sets interrupt enables and writing ones to 0x004 clears them. Zero bits have no effect. Both offsets read back the enable vector.
- R4: Writing ones to 0x008 sets status bits and writing ones to 0x00C clears them. Both offsets read the status. Offset 0x010 reads status AND enable, and `irq` is high exactly when that masked value is nonzero.
- R5: A control write (offset 0x014, code in bits [2:0], bit 4 low) with a legal code drives `cmd_valid` high from the next cycle. Legal codes are 001 read, 010 write, 011 row write, 100 erase and 111 mass erase. The write must arrive while idle and with status bits 0–2 clear. While `cmd_valid` is high, `cmd_code`, `cmd_addr` and `cmd_wdata` hold. The control register reads the code, and the state register (0x018) reads bit 0 pending.
- R6: When `cmd_valid` and `cmd_ready` are both high at a clock edge, `cmd_valid` drops, the control register clears, status bit 0 (accept) is set, and state bit 1 (accepted) is set.
- R7: A response (`rsp_valid`) after acceptance finishes the command and sets state bit 4 (finished). Without `rsp_err` it sets status bit 1 and state bit 2, and a read command loads `rsp_rdata` into the data register (0x020). With `rsp_err` it sets status bit 2 and state bit 3 and leaves the data register unchanged.
- R8: A write to control (bit 4 low), address (0x01C) or data (0x020) is ignored and sets status bit 3 (reject) when it arrives while a command is pending or awaiting a response, or while any of status bits 0–2 is set.
- R9: A control write with bit 4 set raises `cmd_abort` for exactly one cycle. Its code field is ignored, it is never rejected, and it leaves any command in flight untouched.
- R10: Control writes with codes 000, 101 or 110 start no command and leave the control register at zero.
- R11: State bit 1 (accepted) clears when software clears status bit 1 or status bit 2.
- R12: When hardware sets a status bit in the same cycle that software clears it, the bit ends up set.
- R13: A high level on `hw_evt[k]` sets status bit 4+k (4 read overflow, 5 power change, 6 partition mode, 7 access violation).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| pstrb | input | 4 | APB byte strobes; all must be high for a write to act |
| prdata | output | 32 | APB read data |
| cmd_valid | output | 1 | Command request to the flash bus |
| cmd_code | output | 3 | Command code presented with the request |
| cmd_abort | output | 1 | One-cycle abort request |
| cmd_addr | output | 22 | Flash address for the command |
| cmd_wdata | output | 32 | Write data for the command |
| cmd_ready | input | 1 | Flash bus takes the request |
| rsp_valid | input | 1 | Command completion |
| rsp_err | input | 1 | Completion carries an error |
| rsp_rdata | input | 32 | Data returned by a read |
| hw_evt | input | 4 | Event inputs for status bits 4–7 |
| irq | output | 1 | Interrupt, OR of masked status |

## Verification
The sharpest same-cycle meeting is between the flash side accepting a command and software clearing the accept status bit. The bench first forces the accept bit high with a status-set write while the request is still waiting. It then raises `cmd_ready` in the very access cycle of a status-clear write of bit 0. It judges that the bit reads back as one, with the request gone and the accepted flag up. A second meeting is a reprogramming write landing while results are unserviced. There the bench checks that the reject bit rises and that the address and data registers still read their earlier values.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

  localparam int unsigned IRQ_N   = 8;
  localparam int unsigned EXT_N   = IRQ_N - 4;
  localparam int unsigned NREG    = 9;

  // register slot indices, byte offset = 4 * index
  localparam int unsigned SLOT_EN_SET = 0;
  localparam int unsigned SLOT_EN_CLR = 1;
  localparam int unsigned SLOT_ST_SET = 2;
  localparam int unsigned SLOT_ST_CLR = 3;
  localparam int unsigned SLOT_MASKED = 4;
  localparam int unsigned SLOT_CTRL   = 5;
  localparam int unsigned SLOT_STATE  = 6;
  localparam int unsigned SLOT_ADDR   = 7;
  localparam int unsigned SLOT_DATA   = 8;

  // interrupt bit positions
  localparam int unsigned IB_ACCEPT = 0;
  localparam int unsigned IB_OK     = 1;
  localparam int unsigned IB_FAIL   = 2;
  localparam int unsigned IB_REJECT = 3;

  localparam int unsigned CTRL_ABORT_BIT = 4;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_PEND = 2'd1,
    ENG_WAIT = 2'd2
  } eng_state_e;

  localparam logic [2:0] OP_NONE  = 3'b000;
  localparam logic [2:0] OP_READ  = 3'b001;
  localparam logic [2:0] OP_WRITE = 3'b010;
  localparam logic [2:0] OP_ROW   = 3'b011;
  localparam logic [2:0] OP_ERASE = 3'b100;
  localparam logic [2:0] OP_MASS  = 3'b111;

  function automatic logic op_legal(input logic [2:0] code);
    return (code == OP_READ) || (code == OP_WRITE) || (code == OP_ROW) ||
           (code == OP_ERASE) || (code == OP_MASS);
  endfunction

endpackage

// File: rtl/fcc_apb_dec.sv
module fcc_apb_dec #(
  parameter int unsigned PADDR_W = 12,
  parameter int unsigned NSLOT   = 9
) (
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [PADDR_W-1:0] paddr,
  input  logic [3:0]         pstrb,
  output logic [NSLOT-1:0]   wr_hit,
  output logic [NSLOT-1:0]   rd_hit
);

  localparam int unsigned IDX_W = PADDR_W - 2;

  logic full_wr;

  always_comb begin
    full_wr = psel & penable & pwrite & (&pstrb);
  end

  for (genvar gi = 0; gi < NSLOT; gi++) begin : g_slot
    logic sel;
    always_comb begin
      sel        = (paddr[PADDR_W-1:2] == IDX_W'(gi)) && (paddr[1:0] == 2'b00);
      wr_hit[gi] = full_wr & sel;
      rd_hit[gi] = sel;
    end
  end

endmodule

// File: rtl/fcc_irq_bank.sv
module fcc_irq_bank #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] wbits,
  input  logic         en_set_wr,
  input  logic         en_clr_wr,
  input  logic         st_set_wr,
  input  logic         st_clr_wr,
  input  logic [N-1:0] hw_set,
  output logic [N-1:0] en_q,
  output logic [N-1:0] st_q,
  output logic [N-1:0] masked,
  output logic         irq
);

  logic [N-1:0] en_d;
  logic [N-1:0] st_d;
  logic         en_ce;
  logic         st_ce;

  always_comb begin
    en_ce = en_set_wr | en_clr_wr;
    en_d  = (en_q & ~({N{en_clr_wr}} & wbits)) | ({N{en_set_wr}} & wbits);
    st_ce = st_set_wr | st_clr_wr | (|hw_set);
    // hardware set is applied last so it wins over a software clear
    st_d  = (st_q & ~({N{st_clr_wr}} & wbits)) | ({N{st_set_wr}} & wbits) | hw_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      st_q <= '0;
    end else begin
      if (en_ce) en_q <= en_d;
      if (st_ce) st_q <= st_d;
    end
  end

  always_comb begin
    masked = st_q & en_q;
    irq    = |masked;
  end

  // R12
  hw_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_set) |=> ((st_q & $past(hw_set)) == $past(hw_set)));

  // R3
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_clr_wr && !en_set_wr) |=> ((en_q & $past(wbits)) == '0));

  // R4
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_clr_wr && (&wbits) && (hw_set == '0)) |=> !irq);

endmodule

// File: rtl/fcc_cmd_engine.sv
module fcc_cmd_engine
  import fcc_pkg::*;
#(
  parameter int unsigned ADDR_W = 22,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_addr,
  input  logic              wr_data,
  input  logic [DATA_W-1:0] wdata,
  input  logic              results_open,
  input  logic              sw_clr_result,
  input  logic              cmd_ready,
  input  logic              rsp_valid,
  input  logic              rsp_err,
  input  logic [DATA_W-1:0] rsp_rdata,
  output logic              cmd_valid,
  output logic [2:0]        cmd_code,
  output logic              cmd_abort,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic [2:0]        ctrl_q,
  output logic [4:0]        state_view,
  output logic              evt_accept,
  output logic              evt_ok,
  output logic              evt_err,
  output logic              evt_reject
);

  eng_state_e        state_q, state_d;
  logic [2:0]        op_q, op_d;
  logic [2:0]        ctrl_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] data_d;
  logic              acc_q, acc_d;
  logic              ok_q, ok_d;
  logic              err_q, err_d;
  logic              fin_q, fin_d;
  logic              abort_q, abort_d;

  logic blocked;
  logic abort_wr;
  logic prog_wr;
  logic start;
  logic accept;
  logic finish;

  always_comb begin
    blocked  = (state_q != ENG_IDLE) | results_open;
    abort_wr = wr_ctrl & wdata[CTRL_ABORT_BIT];
    prog_wr  = (wr_ctrl & ~wdata[CTRL_ABORT_BIT]) | wr_addr | wr_data;
    start    = wr_ctrl & ~wdata[CTRL_ABORT_BIT] & ~blocked & op_legal(wdata[2:0]);
    accept   = (state_q == ENG_PEND) & cmd_ready;
    finish   = (state_q == ENG_WAIT) & rsp_valid;
  end

  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    ctrl_d  = ctrl_q;
    addr_d  = addr_q;
    data_d  = data_q;
    acc_d   = acc_q;
    ok_d    = ok_q;
    err_d   = err_q;
    fin_d   = fin_q;
    abort_d = abort_wr;

    if (wr_addr && !blocked) addr_d = wdata[ADDR_W-1:0];
    if (wr_data && !blocked) data_d = wdata;

    if (sw_clr_result) acc_d = 1'b0;

    case (state_q)
      ENG_IDLE: begin
        if (start) begin
          state_d = ENG_PEND;
          op_d    = wdata[2:0];
          ctrl_d  = wdata[2:0];
          ok_d    = 1'b0;
          err_d   = 1'b0;
          fin_d   = 1'b0;
        end
      end
      ENG_PEND: begin
        if (accept) begin
          state_d = ENG_WAIT;
          ctrl_d  = OP_NONE;
          acc_d   = 1'b1;
        end
      end
      ENG_WAIT: begin
        if (finish) begin
          state_d = ENG_IDLE;
          fin_d   = 1'b1;
          if (rsp_err) begin
            err_d = 1'b1;
          end else begin
            ok_d = 1'b1;
            if (op_q == OP_READ) data_d = rsp_rdata;
          end
        end
      end
      default: state_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      op_q    <= OP_NONE;
      ctrl_q  <= OP_NONE;
      addr_q  <= '0;
      data_q  <= '0;
      acc_q   <= 1'b0;
      ok_q    <= 1'b0;
      err_q   <= 1'b0;
      fin_q   <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      ctrl_q  <= ctrl_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
      acc_q   <= acc_d;
      ok_q    <= ok_d;
      err_q   <= err_d;
      fin_q   <= fin_d;
      abort_q <= abort_d;
    end
  end

  always_comb begin
    cmd_valid  = (state_q == ENG_PEND);
    cmd_code   = op_q;
    cmd_abort  = abort_q;
    state_view = {fin_q, err_q, ok_q, acc_q, (state_q == ENG_PEND)};
    evt_accept = accept;
    evt_ok     = finish & ~rsp_err;
    evt_err    = finish & rsp_err;
    evt_reject = prog_wr & blocked;
  end

  // R5
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_code) && $stable(addr_q) && $stable(data_q)));

  // R6
  accept_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (!cmd_valid && (ctrl_q == OP_NONE) && state_view[1]));

  // R8
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_reject && !rsp_valid) |=> ($stable(addr_q) && $stable(data_q) && !$rose(cmd_valid)));

  // R9
  abort_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_abort |=> !cmd_abort);

  // R7
  fail_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && rsp_err && !wr_data) |=> ($stable(data_q) && state_view[3] && state_view[4]));

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fcc_pkg::*;
#(
  parameter int unsigned PADDR_W = 12,
  parameter int unsigned ADDR_W  = 22,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [PADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0]  pwdata,
  input  logic [3:0]         pstrb,
  output logic [DATA_W-1:0]  prdata,
  output logic               cmd_valid,
  output logic [2:0]         cmd_code,
  output logic               cmd_abort,
  output logic [ADDR_W-1:0]  cmd_addr,
  output logic [DATA_W-1:0]  cmd_wdata,
  input  logic               cmd_ready,
  input  logic               rsp_valid,
  input  logic               rsp_err,
  input  logic [DATA_W-1:0]  rsp_rdata,
  input  logic [EXT_N-1:0]   hw_evt,
  output logic               irq
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  always_comb rst_int_n = rst_sync_q[1];

  logic [NREG-1:0]   wr_hit;
  logic [NREG-1:0]   rd_hit;
  logic [IRQ_N-1:0]  en_q, st_q, masked, hw_set;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [2:0]        ctrl_q;
  logic [4:0]        state_view;
  logic              evt_accept, evt_ok, evt_err, evt_reject;
  logic              results_open, sw_clr_result;

  fcc_apb_dec #(.PADDR_W(PADDR_W), .NSLOT(NREG)) u_dec (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .pstrb(pstrb), .wr_hit(wr_hit), .rd_hit(rd_hit)
  );

  always_comb begin
    hw_set                 = '0;
    hw_set[IB_ACCEPT]      = evt_accept;
    hw_set[IB_OK]          = evt_ok;
    hw_set[IB_FAIL]        = evt_err;
    hw_set[IB_REJECT]      = evt_reject;
    hw_set[IRQ_N-1:4]      = hw_evt;
    results_open           = st_q[IB_ACCEPT] | st_q[IB_OK] | st_q[IB_FAIL];
    sw_clr_result          = wr_hit[SLOT_ST_CLR] & (pwdata[IB_OK] | pwdata[IB_FAIL]);
  end

  fcc_irq_bank #(.N(IRQ_N)) u_irq (
    .clk(clk), .rst_n(rst_int_n), .wbits(pwdata[IRQ_N-1:0]),
    .en_set_wr(wr_hit[SLOT_EN_SET]), .en_clr_wr(wr_hit[SLOT_EN_CLR]),
    .st_set_wr(wr_hit[SLOT_ST_SET]), .st_clr_wr(wr_hit[SLOT_ST_CLR]),
    .hw_set(hw_set), .en_q(en_q), .st_q(st_q), .masked(masked), .irq(irq)
  );

  fcc_cmd_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst_n(rst_int_n),
    .wr_ctrl(wr_hit[SLOT_CTRL]), .wr_addr(wr_hit[SLOT_ADDR]), .wr_data(wr_hit[SLOT_DATA]),
    .wdata(pwdata), .results_open(results_open), .sw_clr_result(sw_clr_result),
    .cmd_ready(cmd_ready), .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_abort(cmd_abort),
    .addr_q(addr_q), .data_q(data_q), .ctrl_q(ctrl_q), .state_view(state_view),
    .evt_accept(evt_accept), .evt_ok(evt_ok), .evt_err(evt_err), .evt_reject(evt_reject)
  );

  always_comb begin
    cmd_addr  = addr_q;
    cmd_wdata = data_q;
  end

  logic [DATA_W-1:0] view [NREG];

  always_comb begin
    view[SLOT_EN_SET] = DATA_W'(en_q);
    view[SLOT_EN_CLR] = DATA_W'(en_q);
    view[SLOT_ST_SET] = DATA_W'(st_q);
    view[SLOT_ST_CLR] = DATA_W'(st_q);
    view[SLOT_MASKED] = DATA_W'(masked);
    view[SLOT_CTRL]   = DATA_W'(ctrl_q);
    view[SLOT_STATE]  = DATA_W'(state_view);
    view[SLOT_ADDR]   = DATA_W'(addr_q);
    view[SLOT_DATA]   = data_q;
    prdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_hit[i]) prdata = prdata | view[i];
    end
  end

  // R2
  strobe_ignore_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (psel && penable && pwrite && !(&pstrb)) |=> ($stable(en_q) && $stable(addr_q) && $stable(ctrl_q)));

endmodule

// File: tb/sim_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_flash_cmd_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        psel, penable, pwrite;
  logic [11:0] paddr;
  logic [31:0] pwdata;
  logic [3:0]  pstrb;
  logic [31:0] prdata;
  logic        cmd_valid, cmd_abort, cmd_ready, rsp_valid, rsp_err, irq;
  logic [2:0]  cmd_code;
  logic [21:0] cmd_addr;
  logic [31:0] cmd_wdata, rsp_rdata;
  logic [3:0]  hw_evt;

  int   n_vec = 0;
  int   n_bad = 0;
  logic abort_seen;

  always #2 clk = ~clk;

  flash_cmd_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb), .prdata(prdata),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_abort(cmd_abort),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .hw_evt(hw_evt), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apb(input bit wr, input logic [11:0] a, input logic [31:0] d,
                     input logic [3:0] s, input bit rdy, output logic [31:0] rv);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d; pstrb = s;
    @(negedge clk);
    penable = 1'b1;
    if (rdy) cmd_ready = 1'b1;
    #1 rv = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; cmd_ready = 1'b0;
    abort_seen = cmd_abort;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] junk;
    apb(1'b1, a, d, 4'hF, 1'b0, junk);
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    apb(1'b0, a, 32'h0, 4'h0, 1'b0, v);
    chk(tag, v, exp);
  endtask

  task automatic take_cmd();
    @(negedge clk); cmd_ready = 1'b1;
    @(negedge clk); cmd_ready = 1'b0;
  endtask

  task automatic respond(input logic err, input logic [31:0] d);
    @(negedge clk); rsp_valid = 1'b1; rsp_err = err; rsp_rdata = d;
    @(negedge clk); rsp_valid = 1'b0; rsp_err = 1'b0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 9; i++) rd_chk("R1 reg reset", 12'(i * 4), 32'h0);
    chk("R1 cmd_valid", {31'h0, cmd_valid}, 32'h0);
    chk("R1 cmd_abort", {31'h0, cmd_abort}, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_strobe();
    logic [31:0] junk;
    apb(1'b1, 12'h000, 32'hFF, 4'b0111, 1'b0, junk);
    rd_chk("R2 enable untouched", 12'h000, 32'h0);
    apb(1'b1, 12'h01C, 32'h3FFFFF, 4'b1110, 1'b0, junk);
    rd_chk("R2 addr untouched", 12'h01C, 32'h0);
    apb(1'b1, 12'h014, 32'h2, 4'b0001, 1'b0, junk);
    chk("R2 no command", {31'h0, cmd_valid}, 32'h0);
  endtask

  task automatic t_irq_regs();
    wr(12'h000, 32'h0A);
    rd_chk("R3 en set", 12'h000, 32'h0A);
    rd_chk("R3 en read alias", 12'h004, 32'h0A);
    wr(12'h004, 32'h02);
    rd_chk("R3 en clr", 12'h000, 32'h08);
    wr(12'h008, 32'h0C);
    rd_chk("R4 st set", 12'h008, 32'h0C);
    rd_chk("R4 st alias", 12'h00C, 32'h0C);
    rd_chk("R4 masked", 12'h010, 32'h08);
    chk("R4 irq high", {31'h0, irq}, 32'h1);
    wr(12'h00C, 32'h08);
    rd_chk("R4 masked after clr", 12'h010, 32'h0);
    chk("R4 irq low", {31'h0, irq}, 32'h0);
    rd_chk("R4 st remaining", 12'h008, 32'h04);
    wr(12'h00C, 32'hFF);
    wr(12'h004, 32'hFF);
    rd_chk("R3 en all clear", 12'h000, 32'h0);
  endtask

  task automatic t_ext();
    @(negedge clk); hw_evt = 4'b1001;
    @(negedge clk); hw_evt = 4'b0000;
    rd_chk("R13 ext status", 12'h008, 32'h90);
    wr(12'h00C, 32'hF0);
    rd_chk("R13 ext cleared", 12'h008, 32'h0);
  endtask

  task automatic t_write_cmd();
    wr(12'h01C, 32'h2ABCDE);
    wr(12'h020, 32'h12345678);
    wr(12'h014, 32'h2);
    chk("R5 valid", {31'h0, cmd_valid}, 32'h1);
    chk("R5 code", {29'h0, cmd_code}, 32'h2);
    chk("R5 addr", {10'h0, cmd_addr}, 32'h2ABCDE);
    chk("R5 wdata", cmd_wdata, 32'h12345678);
    rd_chk("R5 ctrl view", 12'h014, 32'h2);
    rd_chk("R5 state pending", 12'h018, 32'h01);
    wr(12'h01C, 32'h111);
    rd_chk("R8 reject while pending", 12'h008, 32'h08);
    rd_chk("R8 addr kept", 12'h01C, 32'h2ABCDE);
    wr(12'h00C, 32'h08);
    take_cmd();
    chk("R6 valid drop", {31'h0, cmd_valid}, 32'h0);
    rd_chk("R6 ctrl cleared", 12'h014, 32'h0);
    rd_chk("R6 accept status", 12'h008, 32'h01);
    rd_chk("R6 state accepted", 12'h018, 32'h02);
    respond(1'b0, 32'h55AA55AA);
    rd_chk("R7 ok status", 12'h008, 32'h03);
    rd_chk("R7 state ok", 12'h018, 32'h16);
    rd_chk("R7 write keeps data", 12'h020, 32'h12345678);
    wr(12'h020, 32'h0);
    rd_chk("R8 reject on open result", 12'h008, 32'h0B);
    rd_chk("R8 data kept", 12'h020, 32'h12345678);
    wr(12'h014, 32'h1);
    chk("R8 ctrl refused", {31'h0, cmd_valid}, 32'h0);
    wr(12'h00C, 32'h02);
    rd_chk("R11 accepted cleared", 12'h018, 32'h14);
    wr(12'h00C, 32'h0F);
  endtask

  task automatic t_read_cmd();
    wr(12'h01C, 32'h100);
    wr(12'h014, 32'h1);
    chk("R5 read code", {29'h0, cmd_code}, 32'h1);
    take_cmd();
    respond(1'b0, 32'hCAFEF00D);
    rd_chk("R7 read capture", 12'h020, 32'hCAFEF00D);
    rd_chk("R7 read status", 12'h008, 32'h03);
    wr(12'h00C, 32'h0F);
  endtask

  task automatic t_fail();
    wr(12'h014, 32'h4);
    chk("R5 erase code", {29'h0, cmd_code}, 32'h4);
    take_cmd();
    respond(1'b1, 32'hDEADBEEF);
    rd_chk("R7 fail status", 12'h008, 32'h05);
    rd_chk("R7 fail state", 12'h018, 32'h1A);
    rd_chk("R7 fail keeps data", 12'h020, 32'hCAFEF00D);
    wr(12'h00C, 32'h04);
    rd_chk("R11 accepted cleared by fail clr", 12'h018, 32'h18);
    wr(12'h00C, 32'h0F);
  endtask

  task automatic t_reserved();
    logic [2:0] codes [3] = '{3'b101, 3'b110, 3'b000};
    foreach (codes[k]) begin
      wr(12'h014, {29'h0, codes[k]});
      chk("R10 no start", {31'h0, cmd_valid}, 32'h0);
      rd_chk("R10 ctrl zero", 12'h014, 32'h0);
    end
    rd_chk("R10 no reject", 12'h008, 32'h0);
  endtask

  task automatic t_abort();
    wr(12'h014, 32'h12);
    chk("R9 abort pulse", {31'h0, abort_seen}, 32'h1);
    chk("R9 code ignored", {31'h0, cmd_valid}, 32'h0);
    @(negedge clk);
    chk("R9 abort one cycle", {31'h0, cmd_abort}, 32'h0);
    wr(12'h014, 32'h3);
    wr(12'h014, 32'h10);
    chk("R9 abort in flight", {31'h0, abort_seen}, 32'h1);
    chk("R9 command kept", {31'h0, cmd_valid}, 32'h1);
    chk("R9 code kept", {29'h0, cmd_code}, 32'h3);
    rd_chk("R9 not rejected", 12'h008, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] junk;
    wr(12'h008, 32'h01);
    apb(1'b1, 12'h00C, 32'h01, 4'hF, 1'b1, junk);
    chk("R12 taken", {31'h0, cmd_valid}, 32'h0);
    rd_chk("R12 set wins", 12'h008, 32'h01);
    rd_chk("R12 accepted flag", 12'h018, 32'h02);
    respond(1'b0, 32'h0);
    rd_chk("R7 after collision", 12'h008, 32'h03);
    wr(12'h00C, 32'h0F);
    rd_chk("R11 clear all", 12'h018, 32'h14);
  endtask

  initial begin
    rst_n = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0; paddr = '0;
    pwdata = '0; pstrb = '0; cmd_ready = 1'b0; rsp_valid = 1'b0; rsp_err = 1'b0;
    rsp_rdata = '0; hw_evt = '0; abort_seen = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    fork
      begin
        t_reset();
        t_strobe();
        t_irq_regs();
        t_ext();
        t_write_cmd();
        t_read_cmd();
        t_fail();
        t_reserved();
        t_abort();
        t_collide();
      end
      begin
        repeat (50000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 50000, 0);
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule